// File: doc/BRIEF.md
# Bus Regulation Gain Scheduler

This block picks the transconductance setting for the loop that holds the DC bus of a ballast at its regulation level. The setting changes as the lamp starts. It is high while the bus is first charging, so the bus rises quickly. It drops to low once the bus passes an intermediate level, which limits overshoot. It goes back to high once the bus reaches the regulation level, so the loop can suppress transients during ignition. It falls to the lowest setting in run mode, where the loop needs high power factor and low distortion.

The two bus comparator flags enter asynchronously. Each one passes through a two-stage synchronizer and then a stability filter before the sequencer acts on it. The ballast mode inputs (preheat, ignite, run, fault) are synchronous to the clock. A fault forces the lowest setting immediately and sends the sequencer back to its start-up state. After a fault or after leaving run mode, the low-gain step is armed again only once the intermediate-level flag has been seen low.

Top module: `bus_gain_sched`

## Requirements
- R1: While rst_ni is low, and after it is released, state_o is START (2'd0) and gain_sel_o is 2'b11.
- R2: The state codes are START=0, LOW=1, REG_HIGH=2 and RUN=3. With fault_i low, gain_sel_o is 2'b11 in START and REG_HIGH, 2'b01 in LOW and 2'b00 in RUN. The value 2'b10 never appears on gain_sel_o.
- R3: In START, with the step armed and preheat_i or ignite_i high, a rise of bus_above_low_i moves the state to LOW. The move happens on the (3+STABLE_CYC)-th rising edge after the input changes (5 edges by default).
- R4: In LOW, with preheat_i or ignite_i high, a rise of bus_above_reg_i moves the state to REG_HIGH with the same latency as R3.
- R5: Threshold steps are taken only while preheat_i or ignite_i is high. Otherwise START and LOW hold. A step that was held back is taken on the first edge after preheat_i or ignite_i rises.
- R6: A comparator flag that stays at a new level for fewer than STABLE_CYC cycles at the synchronizer output has no effect on state_o. A flag that holds for STABLE_CYC cycles is accepted.
- R7: With fault_i low, run_i high moves the state to RUN on the next edge from any state, ahead of any threshold step. Dropping run_i in RUN returns the state to START on the next edge.
- R8: fault_i high forces gain_sel_o to 2'b00 in the same cycle, and the state becomes START on the next edge. fault_i takes priority over run_i.
- R9: After reset, a fault, or an exit from RUN, START moves to LOW only after the filtered low-threshold flag has been seen low at least once.
- R10: REG_HIGH holds while fault_i and run_i stay low, whatever the comparator flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_above_low_i | input | 1 | Bus above intermediate threshold (asynchronous) |
| bus_above_reg_i | input | 1 | Bus above regulation threshold (asynchronous) |
| preheat_i | input | 1 | Ballast in preheat |
| ignite_i | input | 1 | Ballast in ignition |
| run_i | input | 1 | Ballast in run mode |
| fault_i | input | 1 | Ballast fault |
| gain_sel_o | output | 2 | Gain select code |
| state_o | output | 2 | Scheduler state code |

## Verification
The gain forced by a fault is due in the same cycle that fault_i rises. Mode-driven state changes from run_i and fault_i are due one edge later. A threshold-driven step is due on the fifth edge after the comparator input changes: two synchronizer stages, two filter cycles and one state register.

The bench drives every input at a falling edge and counts rising edges from there. For each threshold step it samples once after four edges, where the old state must still show, and once after five, where the new state must show. Gain values forced by a fault are checked one time step after the input is applied, before any edge.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic [1:0] {
    ST_START  = 2'd0,
    ST_LOW    = 2'd1,
    ST_REGHI  = 2'd2,
    ST_RUN    = 2'd3
  } sched_st_e;

  localparam logic [1:0] GAIN_HIGH = 2'b11;
  localparam logic [1:0] GAIN_LOW  = 2'b01;
  localparam logic [1:0] GAIN_RUN  = 2'b00;

  localparam int FLAG_LOW = 0;
  localparam int FLAG_REG = 1;
  localparam int NFLAG    = 2;
endpackage

// File: rtl/bgs_flag_filter.sv
module bgs_flag_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(STABLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;
  logic [CNT_W-1:0]       cnt_q;
  logic                   filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], flag_i};
  end

  assign sync_out = sync_q[SYNC_STAGES-1];

  // accept a new level only after it persists STABLE_CYC cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (sync_out == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      filt_q <= sync_out;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flag_o = filt_q;
endmodule

// File: rtl/bgs_seq_fsm.sv
module bgs_seq_fsm
  import bgs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      low_f_i,
  input  logic      reg_f_i,
  input  logic      preheat_i,
  input  logic      ignite_i,
  input  logic      run_i,
  input  logic      fault_i,
  output sched_st_e state_o
);
  sched_st_e st_q, st_d;
  logic      armed_q, armed_d;
  logic      step_en;

  assign step_en = preheat_i | ignite_i;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    if (fault_i) begin
      st_d    = ST_START;
      armed_d = 1'b0;
    end else if (run_i) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_START: begin
          if (!low_f_i)                 armed_d = 1'b1;
          else if (armed_q && step_en)  st_d    = ST_LOW;
        end
        ST_LOW: begin
          if (reg_f_i && step_en) st_d = ST_REGHI;
        end
        ST_REGHI: st_d = ST_REGHI;
        ST_RUN: begin
          st_d    = ST_START;
          armed_d = 1'b0;
        end
        default: st_d = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_START;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/bgs_gain_enc.sv
module bgs_gain_enc
  import bgs_pkg::*;
(
  input  sched_st_e  state_i,
  input  logic       fault_i,
  output logic [1:0] gain_o
);
  always_comb begin
    unique case (state_i)
      ST_LOW:  gain_o = GAIN_LOW;
      ST_RUN:  gain_o = GAIN_RUN;
      default: gain_o = GAIN_HIGH;
    endcase
    if (fault_i) gain_o = GAIN_RUN;
  end
endmodule

// File: rtl/bus_gain_sched.sv
module bus_gain_sched
  import bgs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_above_low_i,
  input  logic       bus_above_reg_i,
  input  logic       preheat_i,
  input  logic       ignite_i,
  input  logic       run_i,
  input  logic       fault_i,
  output logic [1:0] gain_sel_o,
  output logic [1:0] state_o
);
  logic [NFLAG-1:0] flag_raw;
  logic [NFLAG-1:0] flag_filt;
  sched_st_e        st;

  assign flag_raw[FLAG_LOW] = bus_above_low_i;
  assign flag_raw[FLAG_REG] = bus_above_reg_i;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flt
    bgs_flag_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .STABLE_CYC  (STABLE_CYC)
    ) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flag_i (flag_raw[i]),
      .flag_o (flag_filt[i])
    );
  end

  bgs_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .low_f_i   (flag_filt[FLAG_LOW]),
    .reg_f_i   (flag_filt[FLAG_REG]),
    .preheat_i (preheat_i),
    .ignite_i  (ignite_i),
    .run_i     (run_i),
    .fault_i   (fault_i),
    .state_o   (st)
  );

  bgs_gain_enc u_enc (
    .state_i (st),
    .fault_i (fault_i),
    .gain_o  (gain_sel_o)
  );

  assign state_o = st;
endmodule

// File: rtl/bus_gain_sched_chk.sv
module bus_gain_sched_chk
  import bgs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_above_low_i,
  input logic       bus_above_reg_i,
  input logic       preheat_i,
  input logic       ignite_i,
  input logic       run_i,
  input logic       fault_i,
  input logic [1:0] gain_sel_o,
  input logic [1:0] state_o
);
  // R8
  p_fault_to_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> state_o == ST_START);

  // R7
  p_run_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !fault_i) |=> state_o == ST_RUN);

  // R3
  p_low_from_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_LOW && $past(state_o) != ST_LOW) |-> $past(state_o) == ST_START);

  // R2
  p_no_code10_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_sel_o != 2'b10);

  // R2
  p_reghi_gain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_REGHI && !fault_i) |-> gain_sel_o == GAIN_HIGH);

  // R5
  p_hold_no_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_i && !run_i && !preheat_i && !ignite_i && state_o != ST_RUN)
      |=> $stable(state_o));

  // R10
  p_reghi_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_REGHI && !fault_i && !run_i) |=> state_o == ST_REGHI);
endmodule

bind bus_gain_sched bus_gain_sched_chk u_chk (.*);

// File: tb/bus_gain_sched_test.sv
module bus_gain_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_low = 1'b0, above_reg = 1'b0;
  logic preheat = 1'b0, ignite = 1'b0, run = 1'b0, fault = 1'b0;
  logic [1:0] gain, state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_gain_sched uut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .bus_above_low_i (above_low),
    .bus_above_reg_i (above_reg),
    .preheat_i       (preheat),
    .ignite_i        (ignite),
    .run_i           (run),
    .fault_i         (fault),
    .gain_sel_o      (gain),
    .state_o         (state)
  );

  function automatic logic [1:0] gain_of(input logic [1:0] st, input logic flt);
    if (flt) return 2'b00;
    case (st)
      2'd1:    return 2'b01;
      2'd3:    return 2'b00;
      default: return 2'b11;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] exp_st);
    logic [1:0] exp_g;
    exp_g = gain_of(exp_st, fault);
    n_chk++;
    if (state !== exp_st || gain !== exp_g) begin
      n_bad++;
      $display("FAIL %s: state=%0d gain=%b expected state=%0d gain=%b",
               req, state, gain, exp_st, exp_g);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {above_low, above_reg, preheat, ignite, run, fault} = '0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1
    @(negedge clk);
    check("R1 in reset", 2'd0);
    do_reset();
    check("R1 after reset", 2'd0);

    // R3 latency, R2 low code
    preheat = 1'b1; above_low = 1'b1;
    tick(LAT-1); check("R3 before step", 2'd0);
    tick(1);     check("R3 R2 step to LOW", 2'd1);
    // R4
    above_reg = 1'b1;
    tick(LAT-1); check("R4 before step", 2'd1);
    tick(1);     check("R4 step to REG_HIGH", 2'd2);
    // R10
    above_low = 1'b0; above_reg = 1'b0;
    tick(8); check("R10 hold", 2'd2);
    // R8
    fault = 1'b1; #1;
    check("R8 same-cycle gain", 2'd2);
    @(negedge clk);
    check("R8 to START", 2'd0);
    // R9
    above_low = 1'b1;
    tick(6);
    fault = 1'b0;
    tick(1);
    check("R8 released", 2'd0);
    tick(10); check("R9 not armed", 2'd0);
    above_low = 1'b0;
    tick(6); check("R9 arming", 2'd0);
    above_low = 1'b1;
    tick(LAT-1); check("R9 before step", 2'd0);
    tick(1);     check("R9 armed step", 2'd1);

    // R6
    do_reset();
    preheat = 1'b1;
    above_low = 1'b1; tick(1); above_low = 1'b0;
    tick(8); check("R6 short pulse ignored", 2'd0);
    above_low = 1'b1; tick(2); above_low = 1'b0;
    tick(LAT-2-1); check("R6 before step", 2'd0);
    tick(1);       check("R6 two-cycle pulse", 2'd1);

    // R5
    do_reset();
    above_low = 1'b1;
    tick(10); check("R5 no mode holds", 2'd0);
    ignite = 1'b1;
    tick(1); check("R5 ignite enables", 2'd1);
    // R7
    above_reg = 1'b1; run = 1'b1;
    tick(1); check("R7 run priority", 2'd3);
    tick(8); check("R7 run hold", 2'd3);
    run = 1'b0;
    tick(1); check("R7 run exit", 2'd0);
    tick(8); check("R9 after run exit", 2'd0);
    // R8
    run = 1'b1; fault = 1'b1;
    tick(1); check("R8 over run", 2'd0);

    // R7 R8 sweep of mode inputs from START
    for (int m = 0; m < 16; m++) begin
      logic [1:0] exp_st;
      do_reset();
      {preheat, ignite, run, fault} = 4'(m);
      #1;
      check("R8 sweep same cycle", 2'd0);
      exp_st = (fault) ? 2'd0 : (run ? 2'd3 : 2'd0);
      tick(1);
      check("R7 sweep next edge", exp_st);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule